// File: doc/BRIEF.md
# Go/Done Schedule Sequencer

This block steps a fixed schedule of four sub-units, each driven through a go/done handshake. The schedule is: unit A; then a loop that runs either unit B or unit C on each pass, chosen by a select condition; then unit D. A binary state register holds the position in the schedule. Each loop-continue and branch-select decision is folded into the guards of the state transitions, so no state is spent on evaluating conditions. A unit is modelled as any logic that raises its done for one cycle after it has seen go for one or more cycles.

A run starts when the top-level go is high while the sequencer waits in its start state. That start state is also the state of unit A, because the schedule opens with a plain unit and not with a branch. When unit D finishes, the overall done is raised for one cycle and the sequencer returns to its start state. A static mode input picks between two timings. In the plain mode, one idle cycle separates a unit's done from the next unit's go. In early-go mode, the next unit's go is raised in the same cycle as the previous unit's done, so that gap is removed.

Top module: `sched_go_ctl`

## Requirements
- R1: While rst_n is low at a rising edge, the sequencer enters its start state: in the following cycle done_o is low, and unit_go is 4'b0000 whenever go_i is low.
- R2: While go_i is low, unit_go stays 4'b0000 and the sequencer keeps its position. A run therefore waits until go_i is asserted.
- R3: In the start state with go_i high, unit A's go (unit_go bit 0) is asserted in that same cycle, with no separate empty start state in front of it.
- R4: In plain mode (early_en low), a unit's go is asserted only while that unit is in its own state and its done (unit_done bit 0=A, 1=B, 2=C, 3=D) is low.
- R5: When A finishes, the sequencer enters B if loop_c and sel_c are both high, enters C if loop_c is high and sel_c is low, and goes straight to D if loop_c is low.
- R6: When B or C finishes, the same conditions decide again: loop_c high re-enters B (sel_c high) or C (sel_c low), and loop_c low moves on to D.
- R7: The cycle after D's done, done_o is high for exactly one cycle. The sequencer then returns to the start state, so with go_i still high unit A starts again in the following cycle.
- R8: In plain mode, a run with unit latencies L1..Lk (k executions) raises done_o exactly sum(Li+1) cycles after the cycle in which go_i first starts A.
- R9: In early-go mode, the next unit's go is asserted in the same cycle as its predecessor's done, including a re-entry of the same unit. done_o is raised sum(Li)+1 cycles after the start cycle.
- R10: At most one bit of unit_go is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go_i | input | 1 | Top-level go; the sequencer advances only while high |
| early_en | input | 1 | 1 = early-go timing, 0 = plain timing; held static during a run |
| loop_c | input | 1 | Loop-continue condition, sampled at A/B/C completion |
| sel_c | input | 1 | Branch select, 1 = B, 0 = C |
| unit_done | input | 4 | Done from units A(0), B(1), C(2), D(3) |
| unit_go | output | 4 | Go to units A(0), B(1), C(2), D(3) |
| done_o | output | 1 | One-cycle pulse when the schedule completes |

## Verification
A wrong state value shows at the ports at once, because unit_go is decoded combinationally from the state. The wrong unit receives go, or no unit does, in the same cycle the state goes wrong. A bad branch or loop guard shows up as a wrong order of unit starts, and the recorded start order exposes it at the completion boundary where the guard is used. A timing fault, such as a missing idle cycle or an early-go term that is not driven, does not change the order but shifts done_o by a fixed number of cycles per unit. The run-length count catches that.

// File: rtl/sgc_pkg.sv
// Package: shared constants and state type for the go/done schedule sequencer.
// Assumes the fixed schedule A ; loop { B or C } ; D with one state per unit.
package sgc_pkg;
    localparam int NUM_UNITS   = 4;
    localparam int FINAL_IDX   = NUM_UNITS;            // state after D
    localparam int ST_W        = $clog2(FINAL_IDX + 1); // minimal width for 0..final
    typedef logic [ST_W-1:0] state_t;
    localparam state_t ST_A    = state_t'(0);  // start state merged with unit A
    localparam state_t ST_B    = state_t'(1);
    localparam state_t ST_C    = state_t'(2);
    localparam state_t ST_D    = state_t'(3);
    localparam state_t ST_FIN  = state_t'(FINAL_IDX);
    localparam int U_A = 0;
    localparam int U_B = 1;
    localparam int U_C = 2;
    localparam int U_D = 3;
endpackage

// File: rtl/sgc_edges.sv
// Module: sgc_edges
// Evaluates the guarded transitions out of the current state. The guard of
// each edge is the done of the unit in the current state combined with the
// loop and select conditions. Assumes unit_done is a registered signal.
module sgc_edges
    import sgc_pkg::*;
(
    input  state_t               st_q,
    input  logic [NUM_UNITS-1:0] unit_done,
    input  logic                 loop_c,
    input  logic                 sel_c,
    output logic                 take,
    output state_t               nxt
);
    logic   body_pd;   // done of A, B or C when in that unit's state
    state_t body_dst;  // target after A/B/C completes

    // Pick the done of the unit owning a loop-predecessor state.
    always_comb begin
        unique case (st_q)
            ST_A:    body_pd = unit_done[U_A];
            ST_B:    body_pd = unit_done[U_B];
            ST_C:    body_pd = unit_done[U_C];
            default: body_pd = 1'b0;
        endcase
    end

    // Loop re-entry by select, or exit to D when the loop condition is low.
    always_comb begin
        if (!loop_c)    body_dst = ST_D;
        else if (sel_c) body_dst = ST_B;
        else            body_dst = ST_C;
    end

    // Choose whether an edge fires and where it leads.
    always_comb begin
        take = 1'b0;
        nxt  = st_q;
        unique case (st_q)
            ST_A, ST_B, ST_C: begin
                take = body_pd;
                nxt  = body_dst;
            end
            ST_D: begin
                take = unit_done[U_D];
                nxt  = ST_FIN;
            end
            default: begin  // final state, and unused codes, go back to start
                take = 1'b1;
                nxt  = ST_A;
            end
        endcase
    end
endmodule

// File: rtl/sgc_state.sv
// Module: sgc_state
// Binary position register. Loads the next state when adv is high.
// Synchronous active-low reset to the start state.
module sgc_state
    import sgc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  state_t nxt,
    output state_t st_q
);
    // Hold or advance the schedule position.
    always_ff @(posedge clk) begin
        if (!rst_n)   st_q <= ST_A;
        else if (adv) st_q <= nxt;
    end
endmodule

// File: rtl/sgc_gogen.sv
// Module: sgc_gogen
// Drives one go per unit: its own-state term while its done is low, plus an
// optional early term while a firing edge targets the unit. The early term is
// not masked by the unit's own done, because each unit runs at least one cycle.
module sgc_gogen
    import sgc_pkg::*;
(
    input  state_t               st_q,
    input  logic                 go_i,
    input  logic                 early_en,
    input  logic [NUM_UNITS-1:0] unit_done,
    input  logic                 take,
    input  state_t               nxt,
    output logic [NUM_UNITS-1:0] unit_go
);
    logic from_unit;  // current state belongs to a unit, not the final state

    // Early starts only come from edges leaving a unit state.
    always_comb from_unit = (st_q <= ST_D);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_go
        logic own_t;
        logic early_t;
        // Own-state go while the unit has not yet reported done.
        always_comb own_t   = (st_q == state_t'(u)) && !unit_done[u];
        // Early go while a predecessor edge into this unit fires.
        always_comb early_t = early_en && from_unit && take && (nxt == state_t'(u));
        // Gate everything with the top-level go.
        always_comb unit_go[u] = go_i && (own_t || early_t);
    end
endmodule

// File: rtl/sched_go_ctl.sv
// Module: sched_go_ctl (top)
// Go/done sequencer for the schedule A ; while(loop_c) { sel_c ? B : C } ; D.
// Assumes every unit raises its done for one cycle, at least one cycle after
// its go, and that early_en is static during a run.
module sched_go_ctl
    import sgc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 early_en,
    input  logic                 loop_c,
    input  logic                 sel_c,
    input  logic [NUM_UNITS-1:0] unit_done,
    output logic [NUM_UNITS-1:0] unit_go,
    output logic                 done_o
);
    state_t st_q;
    state_t nxt;
    logic   take;
    logic   adv;

    sgc_edges u_edges (
        .st_q      (st_q),
        .unit_done (unit_done),
        .loop_c    (loop_c),
        .sel_c     (sel_c),
        .take      (take),
        .nxt       (nxt)
    );

    // Advance while running; the final state always returns to start.
    always_comb adv = take && (go_i || (st_q == ST_FIN));

    sgc_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .nxt   (nxt),
        .st_q  (st_q)
    );

    sgc_gogen u_gogen (
        .st_q      (st_q),
        .go_i      (go_i),
        .early_en  (early_en),
        .unit_done (unit_done),
        .take      (take),
        .nxt       (nxt),
        .unit_go   (unit_go)
    );

    // Overall completion flag.
    always_comb done_o = (st_q == ST_FIN);
endmodule

// File: rtl/sgc_chk.sv
// Module: sgc_chk
// Property checker for sched_go_ctl, attached with bind below.
module sgc_chk
    import sgc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 go_i,
    input logic                 early_en,
    input logic [NUM_UNITS-1:0] unit_done,
    input logic [NUM_UNITS-1:0] unit_go,
    input logic                 done_o,
    input state_t               st_q
);
    // R1
    reset_start_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q == ST_A) && !done_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |-> (unit_go == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_i && !done_o) |=> $stable(st_q));

    // R4
    no_go_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !early_en |-> ((unit_go & unit_done) == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q <= ST_FIN);

    // R10
    go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_go));
endmodule

bind sched_go_ctl sgc_chk u_sgc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .early_en  (early_en),
    .unit_done (unit_done),
    .unit_go   (unit_go),
    .done_o    (done_o),
    .st_q      (st_q)
);

// File: tb/tb_sched_go_ctl.sv
module tb_sched_go_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic       early_en = 1'b0;
    logic       loop_c;
    logic       sel_c;
    logic [3:0] unit_done;
    logic [3:0] unit_go;
    logic       done_o;

    always #10 clk = ~clk;  // 50 MHz

    sched_go_ctl dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .early_en(early_en),
        .loop_c(loop_c), .sel_c(sel_c), .unit_done(unit_done),
        .unit_go(unit_go), .done_o(done_o)
    );

    int nchk = 0;
    int nfail = 0;
    int gcyc = 0;

    // Unit responders: done one cycle after lat[u] cycles of go.
    int lat [4];
    int rcnt [4];
    always @(posedge clk) begin
        for (int u = 0; u < 4; u++) begin
            if (!rst_n)                rcnt[u] <= 0;
            else if (rcnt[u] == lat[u]) rcnt[u] <= unit_go[u] ? 1 : 0;
            else if (unit_go[u])       rcnt[u] <= rcnt[u] + 1;
        end
    end
    always_comb for (int u = 0; u < 4; u++) unit_done[u] = (rcnt[u] == lat[u]);

    // Condition source: iteration count and branch pattern.
    int         iter;
    int         n_iter;
    logic [7:0] pat;
    logic       clr_iter = 1'b0;
    int         comp;
    always @(posedge clk) begin
        if (clr_iter)                       iter <= 0;
        else if (unit_done[1] | unit_done[2]) iter <= iter + 1;
    end
    always_comb begin
        comp   = iter + ((unit_done[1] | unit_done[2]) ? 1 : 0);
        loop_c = (comp < n_iter);
        sel_c  = (comp < 8) ? pat[comp[2:0]] : 1'b0;
    end

    // Start recorder, sampled at the falling edge.
    logic rec_en = 1'b0;
    int   nlog;
    int   slog [16];
    int   multi;
    int   overlap;
    always @(negedge clk) begin
        if (rec_en) begin
            if ($countones(unit_go) > 1) multi++;
            if (!early_en && ((unit_go & unit_done) != 4'b0000)) overlap++;
            for (int u = 0; u < 4; u++)
                if (unit_go[u] && (rcnt[u] == 0 || unit_done[u])) begin
                    if (nlog < 16) slog[nlog] = u;
                    nlog++;
                end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // One schedule run; checks start order and run length.
    task automatic run(input logic early, input int n, input logic [7:0] p,
                       input int la, input int lb, input int lc, input int ld,
                       input logic keep_go);
        int cyc;
        int sum;
        int exp_cyc;
        int exp_ord [16];
        int nexp;
        lat[0] = la; lat[1] = lb; lat[2] = lc; lat[3] = ld;
        n_iter = n; pat = p;
        @(posedge clk); #2 clr_iter = 1'b1;
        @(posedge clk); #2 clr_iter = 1'b0;
        nlog = 0; multi = 0; overlap = 0;
        early_en = early; rec_en = 1'b1; go_i = 1'b1;
        exp_ord[0] = 0; nexp = 1; sum = la + ld;
        for (int k = 0; k < n; k++) begin
            exp_ord[nexp] = p[k] ? 1 : 2; nexp++;
            sum += p[k] ? lb : lc;
        end
        exp_ord[nexp] = 3; nexp++;
        exp_cyc = early ? sum + 1 : sum + nexp;
        @(negedge clk);
        cyc = 0;
        chk(unit_go == 4'b0001, "R3 A go in start cycle", int'(unit_go), 1);
        while (!done_o && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        rec_en = 1'b0;
        chk(cyc == exp_cyc, early ? "R9 early run length" : "R8 plain run length", cyc, exp_cyc);
        chk(nlog == nexp, "R5/R6 start count", nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            chk(slog[i] == exp_ord[i], (i == 1) ? "R5 order after A" : "R6 order", slog[i], exp_ord[i]);
        chk(multi == 0, "R10 single go", multi, 0);
        if (!early) chk(overlap == 0, "R4 go low during done", overlap, 0);
        if (!keep_go) begin
            @(posedge clk); #2 go_i = 1'b0;
            @(negedge clk);
            chk(!done_o, "R7 done one cycle", int'(done_o), 0);
            chk(unit_go == 4'b0000, "R7 idle after done", int'(unit_go), 0);
        end else begin
            @(negedge clk);
            chk(!done_o, "R7 done one cycle", int'(done_o), 0);
            chk(unit_go == 4'b0001, "R7 restart of A", int'(unit_go), 1);
        end
    endtask

    // {early, n_iter[2:0], pattern[7:0], LA, LB, LC, LD}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 3'd2, 8'b00000001, 4'd1, 4'd1, 4'd1, 4'd1},
        {1'b0, 3'd3, 8'b00000101, 4'd3, 4'd2, 4'd4, 4'd1},
        {1'b0, 3'd0, 8'b00000000, 4'd2, 4'd5, 4'd5, 4'd3},
        {1'b1, 3'd2, 8'b00000001, 4'd1, 4'd1, 4'd1, 4'd1},
        {1'b1, 3'd3, 8'b00000011, 4'd2, 4'd3, 4'd1, 4'd4},
        {1'b1, 3'd0, 8'b00000000, 4'd1, 4'd1, 4'd1, 4'd1},
        {1'b0, 3'd4, 8'b00001111, 4'd1, 4'd2, 4'd1, 4'd2},
        {1'b1, 3'd4, 8'b00000000, 4'd3, 4'd1, 4'd2, 4'd1}
    };

    initial begin
        lat = '{1, 1, 1, 1};
        n_iter = 0; pat = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && unit_go == 4'b0000, "R1 reset state", int'(unit_go), 0);
        // R2: idle while go is low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(unit_go == 4'b0000 && !done_o, "R2 idle without go", int'(unit_go), 0);
        end
        // Table of vectors
        for (int v = 0; v < 8; v++)
            run(VEC[v][27], int'(VEC[v][26:24]), VEC[v][23:16], int'(VEC[v][15:12]),
                int'(VEC[v][11:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0);
        // Randomised latencies in both modes
        for (int r = 0; r < 6; r++)
            run(r[0], int'($urandom_range(0, 5)), 8'($urandom_range(0, 255)),
                int'($urandom_range(1, 6)), int'($urandom_range(1, 6)),
                int'($urandom_range(1, 6)), int'($urandom_range(1, 6)), 1'b0);
        // R7: go held through completion restarts A
        run(1'b0, 1, 8'b1, 2, 2, 2, 2, 1'b1);
        // R1: reset in the middle of a run
        @(posedge clk); #2 rst_n = 1'b0; go_i = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && unit_go == 4'b0000, "R1 reset mid run", int'(unit_go), 0);
        run(1'b0, 2, 8'b10, 4, 1, 3, 2, 1'b0);
        // R2: a late go after a long idle still starts cleanly
        repeat (7) @(negedge clk);
        chk(unit_go == 4'b0000, "R2 held idle", int'(unit_go), 0);
        run(1'b1, 1, 8'b0, 1, 1, 5, 1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule